// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps time of day and calendar date in packed BCD. It counts hundredths of a second, seconds, minutes, hours in 24-hour form, day of week, day of month, month, two-digit year and a one-bit century marker. Each one-cycle pulse on `tick_en` advances the count by one hundredth. The caller provides that pulse at 100 Hz in the system clock domain. The carries ripple through the fields in the same cycle. Month length follows a 28/29/30/31-day table, and February gets 29 days whenever the year is a multiple of four.

Two copies of the time are kept. The counting copy advances on the tick. A user copy is what the read port shows. Every cycle the whole counting copy is moved into the user copy in one transfer, so the fields always agree with each other. While `freeze` is high that transfer is skipped. The counting copy keeps running, so a multi-byte read sees a stable snapshot, and once `freeze` drops the snapshot catches up with no lost time.

Software loads the fields through a byte-wide write port. Any clock write sets the hundredths back to 00, which restarts the sub-second count. A halt flag in the seconds register stops all counting.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the read port returns 00 for hundredths, seconds, minutes, hours and year, 01 for date and month, and 1 for day of week. The halt flag, century flag and century enable are all 0.
- R2: Each accepted tick adds one to the hundredths in BCD. The chain carries 99→00 hundredths into seconds, 59→00 seconds into minutes, 59→00 minutes into hours, and 23→00 hours into the day.
- R3: On the day carry, day of week steps 1..7 and wraps 7→1. The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other non-February months, carrying into the month. Month 12 wraps to 01 and carries into the year.
- R4: February ends after 29 when the binary value of the BCD year is a multiple of 4, including year 00, and after 28 otherwise.
- R5: On the year carry 99→00 the century flag (address 3 bit 6) inverts if the century enable (address 3 bit 7) is 1, and holds if it is 0.
- R6: A write to any address 0..7 sets the hundredths to 00 whatever the data, including writes to address 0. A tick in the same cycle as a write is dropped.
- R7: When the halt flag (address 1 bit 7) is 1, ticks change no field. Clearing it lets counting resume from the held value. The flag reads back in the same bit.
- R8: With `freeze` low, the read port shows the counting copy as it was one cycle earlier. With `freeze` high the read port holds its contents while the counting copy keeps advancing. The first transfer after `freeze` falls shows the full elapsed count.
- R9: Register layout, read and write: 0 hundredths; 1 {halt, seconds[6:0]}; 2 {0, minutes[6:0]}; 3 {century enable, century, hours[5:0]}; 4 {00000, day[2:0]}; 5 {00, date[5:0]}; 6 {000, month[4:0]}; 7 year. Bit positions shown as 0 read back as 0 whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle 100 Hz advance pulse |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address of the write |
| wr_data | input | 8 | Write data |
| freeze | input | 1 | Holds the user copy while high |
| rd_addr | input | 3 | Register address of the read |
| rd_data | output | 8 | User copy of the addressed register, combinational |

## Verification
A register write and an accepted tick can land in the same clock cycle, and only the write may take effect. The bench first ticks the hundredths to a nonzero value. It then raises `tick_en` and `wr_en` on the same edge, and expects hundredths 00 with the written minutes in place. A second collision is a transfer resuming while the counting copy has moved on. The bench freezes the view, ticks across a seconds carry, releases `freeze`, and judges that the snapshot held until release and then showed the full elapsed count.

// File: rtl/bcdcal_pkg.sv
package bcdcal_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int DOW_W  = 3;

  typedef struct packed {
    logic [BYTE_W-1:0] hund;
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] hour;
    logic [DOW_W-1:0]  dow;
    logic [BYTE_W-1:0] date;
    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] year;
    logic              cen;
    logic              cen_en;
    logic              halt;
  } cal_t;

  // Two-digit BCD increment with no wrap handling
  function automatic logic [BYTE_W-1:0] bcd_next(input logic [BYTE_W-1:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  // Binary value of the BCD year, low two bits zero means leap
  function automatic logic is_leap(input logic [BYTE_W-1:0] yr);
    logic [6:0] b;
    b = {3'b0, yr[7:4]} * 7'd10 + {3'b0, yr[3:0]};
    return (b[1:0] == 2'b00);
  endfunction

  // Last valid date of a month, in BCD
  function automatic logic [BYTE_W-1:0] last_day(input logic [BYTE_W-1:0] mon,
                                                 input logic [BYTE_W-1:0] yr);
    case (mon)
      8'h02:                      return is_leap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic cal_t cal_reset();
    cal_t c;
    c = '0;
    c.dow  = 3'd1;
    c.date = 8'h01;
    c.mon  = 8'h01;
    return c;
  endfunction
endpackage

// File: rtl/bcdcal_core.sv
module bcdcal_core
  import bcdcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  output cal_t              now_q
);
  cal_t nxt;

  // Named carry events
  logic step, c_hund, c_sec, c_min, c_hour, c_date, c_mon, c_year;
  assign step   = tick_en && !now_q.halt && !wr_en;
  assign c_hund = step   && (now_q.hund == 8'h99);
  assign c_sec  = c_hund && (now_q.sec  == 8'h59);
  assign c_min  = c_sec  && (now_q.min  == 8'h59);
  assign c_hour = c_min  && (now_q.hour == 8'h23);
  assign c_date = c_hour && (now_q.date == last_day(now_q.mon, now_q.year));
  assign c_mon  = c_date && (now_q.mon  == 8'h12);
  assign c_year = c_mon  && (now_q.year == 8'h99);

  always_comb begin
    nxt = now_q;
    if (wr_en) begin
      nxt.hund = '0;
      case (wr_addr)
        3'd1: begin nxt.sec = {1'b0, wr_data[6:0]}; nxt.halt = wr_data[7]; end
        3'd2: nxt.min = {1'b0, wr_data[6:0]};
        3'd3: begin
          nxt.hour   = {2'b0, wr_data[5:0]};
          nxt.cen    = wr_data[6];
          nxt.cen_en = wr_data[7];
        end
        3'd4: nxt.dow  = wr_data[DOW_W-1:0];
        3'd5: nxt.date = {2'b0, wr_data[5:0]};
        3'd6: nxt.mon  = {3'b0, wr_data[4:0]};
        3'd7: nxt.year = wr_data;
        default: ;
      endcase
    end else if (step) begin
      nxt.hund = c_hund ? 8'h00 : bcd_next(now_q.hund);
      if (c_hund) nxt.sec = c_sec ? 8'h00 : bcd_next(now_q.sec);
      if (c_sec)  nxt.min = c_min ? 8'h00 : bcd_next(now_q.min);
      if (c_min)  nxt.hour = c_hour ? 8'h00 : bcd_next(now_q.hour);
      if (c_hour) begin
        nxt.dow  = (now_q.dow == 3'd7) ? 3'd1 : now_q.dow + 3'd1;
        nxt.date = c_date ? 8'h01 : bcd_next(now_q.date);
      end
      if (c_date) nxt.mon  = c_mon ? 8'h01 : bcd_next(now_q.mon);
      if (c_mon)  nxt.year = c_year ? 8'h00 : bcd_next(now_q.year);
      if (c_year && now_q.cen_en) nxt.cen = !now_q.cen;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) now_q <= cal_reset();
    else        now_q <= nxt;
  end

  // R6: a write leaves the hundredths at zero
  a_r6_write_zeroes_hund: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> now_q.hund == 8'h00);
  // R7: halted and not written means nothing moves
  a_r7_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (now_q.halt && !wr_en) |=> $stable(now_q));
  // R5: century flag inverts on an enabled year wrap
  a_r5_century_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (c_year && now_q.cen_en) |=> now_q.cen != $past(now_q.cen));
  // R5: century flag holds on a disabled year wrap
  a_r5_century_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (c_year && !now_q.cen_en) |=> now_q.cen == $past(now_q.cen));
  // R3: date carry restarts the date at 01
  a_r3_date_restart: assert property (@(posedge clk) disable iff (!rst_n)
    c_date |=> (now_q.date == 8'h01 && now_q.mon != $past(now_q.mon)));
  // R2: plain tick without carry advances hundredths, leaves seconds
  a_r2_no_carry_keeps_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !c_hund) |=> (now_q.sec == $past(now_q.sec) && now_q.hund != 8'h00));
endmodule

// File: rtl/bcdcal_view.sv
module bcdcal_view
  import bcdcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              freeze,
  input  cal_t              live,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  cal_t view_q;
  logic xfer;
  assign xfer = !freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    view_q <= cal_reset();
    else if (xfer) view_q <= live;
  end

  always_comb begin
    case (rd_addr)
      3'd0: rd_data = view_q.hund;
      3'd1: rd_data = {view_q.halt, view_q.sec[6:0]};
      3'd2: rd_data = {1'b0, view_q.min[6:0]};
      3'd3: rd_data = {view_q.cen_en, view_q.cen, view_q.hour[5:0]};
      3'd4: rd_data = {{(BYTE_W-DOW_W){1'b0}}, view_q.dow};
      3'd5: rd_data = {2'b0, view_q.date[5:0]};
      3'd6: rd_data = {3'b0, view_q.mon[4:0]};
      default: rd_data = view_q.year;
    endcase
  end

  // R8: frozen view does not move
  a_r8_frozen_view: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> $stable(view_q));
  // R8: open view trails the counting copy by one cycle
  a_r8_view_follows: assert property (@(posedge clk) disable iff (!rst_n)
    !freeze |=> view_q == $past(live));
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import bcdcal_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              freeze,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BYTE_W-1:0] rd_data
);
  cal_t live;

  bcdcal_core u_core (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .now_q(live)
  );

  bcdcal_view u_view (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .live(live),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );
endmodule

// File: tb/bcd_calendar_bench.sv
module bcd_calendar_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick_en = 0, wr_en = 0, freeze = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  bcd_calendar u_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .freeze(freeze),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    rd_addr = a;
    #1;
    checks++;
    if (rd_data !== exp) begin
      errors++;
      $display("FAIL %s addr %0d got %h expected %h", req, a, rd_data, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_en = 1;
    repeat (n) @(negedge clk);
    tick_en = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic set_day(input logic [7:0] yr, input logic [7:0] mo, input logic [7:0] dt,
                         input logic [7:0] hr);
    do_write(7, yr); do_write(6, mo); do_write(5, dt);
    do_write(3, hr); do_write(2, 8'h59); do_write(1, 8'h59);
  endtask

  task automatic test_reset();
    settle();
    chk(0, 8'h00, "R1"); chk(1, 8'h00, "R1"); chk(2, 8'h00, "R1"); chk(3, 8'h00, "R1");
    chk(4, 8'h01, "R1"); chk(5, 8'h01, "R1"); chk(6, 8'h01, "R1"); chk(7, 8'h00, "R1");
  endtask

  task automatic test_count();
    ticks(5); settle(); chk(0, 8'h05, "R2");
    ticks(95); settle(); chk(0, 8'h00, "R2"); chk(1, 8'h01, "R2");
    do_write(4, 8'h07);
    set_day(8'h10, 8'h01, 8'h15, 8'h23);
    ticks(100); settle();
    chk(1, 8'h00, "R2"); chk(2, 8'h00, "R2"); chk(3, 8'h00, "R2");
    chk(4, 8'h01, "R3 dow wrap"); chk(5, 8'h16, "R3");
  endtask

  task automatic test_months();
    set_day(8'h10, 8'h04, 8'h30, 8'h23); ticks(100); settle();
    chk(5, 8'h01, "R3 30-day"); chk(6, 8'h05, "R3 30-day");
    set_day(8'h10, 8'h01, 8'h30, 8'h23); ticks(100); settle();
    chk(5, 8'h31, "R3 31-day");
    set_day(8'h10, 8'h12, 8'h31, 8'h23); ticks(100); settle();
    chk(5, 8'h01, "R3 year carry"); chk(6, 8'h01, "R3"); chk(7, 8'h11, "R3");
  endtask

  task automatic test_leap();
    set_day(8'h24, 8'h02, 8'h28, 8'h23); ticks(100); settle();
    chk(5, 8'h29, "R4 leap"); chk(6, 8'h02, "R4 leap");
    do_write(3, 8'h23); do_write(2, 8'h59); do_write(1, 8'h59);
    ticks(100); settle();
    chk(5, 8'h01, "R4 leap end"); chk(6, 8'h03, "R4 leap end");
    set_day(8'h23, 8'h02, 8'h28, 8'h23); ticks(100); settle();
    chk(5, 8'h01, "R4 common"); chk(6, 8'h03, "R4 common");
    set_day(8'h00, 8'h02, 8'h28, 8'h23); ticks(100); settle();
    chk(5, 8'h29, "R4 year 00");
  endtask

  task automatic test_century();
    set_day(8'h99, 8'h12, 8'h31, 8'hA3); ticks(100); settle();
    chk(7, 8'h00, "R5"); chk(3, 8'hC0, "R5 toggle");
    set_day(8'h99, 8'h12, 8'h31, 8'h63); ticks(100); settle();
    chk(3, 8'h40, "R5 hold"); chk(7, 8'h00, "R5");
  endtask

  task automatic test_write_clear();
    do_write(0, 8'h99); settle(); chk(0, 8'h00, "R6 addr0");
    ticks(37); settle(); chk(0, 8'h37, "R6 pre");
    do_write(4, 8'h03); settle(); chk(0, 8'h00, "R6 clear");
    ticks(7); settle();
    @(negedge clk); tick_en = 1; wr_en = 1; wr_addr = 2; wr_data = 8'h05;
    @(negedge clk); tick_en = 0; wr_en = 0;
    settle(); chk(0, 8'h00, "R6 collision"); chk(2, 8'h05, "R6 collision");
    ticks(1); settle(); chk(0, 8'h01, "R6 after");
  endtask

  task automatic test_halt();
    do_write(1, 8'hB0); ticks(20); settle();
    chk(0, 8'h00, "R7 halted"); chk(1, 8'hB0, "R7 flag");
    do_write(1, 8'h30); ticks(3); settle();
    chk(0, 8'h03, "R7 resume"); chk(1, 8'h30, "R7");
  endtask

  task automatic test_freeze();
    do_write(1, 8'h10); settle();
    @(negedge clk); freeze = 1;
    ticks(150); settle();
    chk(0, 8'h00, "R8 frozen"); chk(1, 8'h10, "R8 frozen");
    @(negedge clk); freeze = 0;
    settle();
    chk(0, 8'h50, "R8 catch-up"); chk(1, 8'h11, "R8 catch-up");
  endtask

  task automatic test_unused();
    do_write(4, 8'hFF); do_write(5, 8'hFF); do_write(6, 8'hFF); do_write(2, 8'hFF);
    settle();
    chk(4, 8'h07, "R9"); chk(5, 8'h3F, "R9"); chk(6, 8'h1F, "R9"); chk(2, 8'h7F, "R9");
    do_write(3, 8'hFF); settle(); chk(3, 8'hFF, "R9 hour bits");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    test_reset();
    test_count();
    test_months();
    test_leap();
    test_century();
    test_write_clear();
    test_halt();
    test_freeze();
    test_unused();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule